// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Front End

This block sits in front of a single-port word-wide memory array and gives it a late-write command protocol. On every rising clock edge it samples a chip select, a write enable, an address and four active-low byte-lane write enables. For a write, the data word arrives one cycle after the command. It is captured into a pending-write buffer together with the registered address and lane enables. The buffer is retired into the array when the next write's data is captured, or when sleep is requested.

Reads are registered: the word appears on the data output one cycle after the read command. A read that targets the address held in the pending buffer is served by merging the buffered lanes over the stored word, so software always sees the newest data. The output pad is driven only for a selected read. The output enable and the sleep input gate the drive asynchronously, and the pad is tri-stated whenever `rdata_en` is low.

Top module: `lwsram_front`

## Requirements
- R1: `cs_n`, `we_n`, `addr` and `lane_we_n` act only through their values at a rising clock edge; a pulse that starts and ends between two edges has no effect.
- R2: A write command sampled at edge n stores the `wdata` present at edge n+1. Lane i covers word bits [9i+8:9i].
- R3: `lane_we_n[i]` low enables lane i of a write. Lanes with their enable high keep their old contents. A write with `lane_we_n` = 4'b1111 changes nothing.
- R4: A read sampled at edge n puts the addressed word on `rdata` at edge n+1. With `oe_n` and `sleep` low, `rdata_en` is high from just after edge n+1 until edge n+2.
- R5: A read of the address of the pending write returns the pending lanes merged over the stored word.
- R6: The pending write is committed to the array when the next write's data is captured. The earlier address then reads back its written data from the array.
- R7: With `cs_n` high at edge n, `rdata_en` is low after edge n+1, and no write takes place.
- R8: `oe_n` high forces `rdata_en` low at once, without a clock edge. A selected read with `oe_n` high completes as a dummy read.
- R9: `sleep` high forces `rdata_en` low at once. Commands sampled while `sleep` is high are ignored.
- R10: A pending write present while `sleep` is high is committed to the array at the next edge, so its data survives a later reset.
- R11: Asynchronous reset (`rst_n` low) clears the drive enable and discards a pending write without storing it. Words already in the array are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable (high means read) |
| addr | input | AW | Word address |
| lane_we_n | input | 4 | Active-low per-lane write enables, bit i for lane i |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Sleep request, active high |
| wdata | input | 36 | Write data, taken one cycle after its command |
| rdata | output | 36 | Read data |
| rdata_en | output | 1 | Pad drive enable; the bus is tri-stated when low |

## Verification
The assertions assume that the command inputs, `wdata`, `oe_n` and `sleep` are known and settled at every rising edge once reset is released. They also assume that a read only targets words written earlier, so that the stored word is defined. The stimulus changes every input on the falling edge, holds command lines idle during reset, and orders its writes ahead of its reads. The asynchronous paths are exercised by toggling `oe_n` and `sleep` mid-cycle, and the checks sample only after a short settle delay.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_t;

  // Expand a per-lane enable into a per-bit mask.
  function automatic word_t lane_bits(lane_t m);
    word_t b;
    for (int i = 0; i < LANES; i++) b[i*LANE_W +: LANE_W] = {LANE_W{m[i]}};
    return b;
  endfunction

  // Overlay the enabled lanes of upd onto base.
  function automatic word_t merge_lanes(word_t base, word_t upd, lane_t m);
    word_t b;
    b = lane_bits(m);
    return (upd & b) | (base & ~b);
  endfunction
endpackage

// File: rtl/lwsram_cmd.sv
module lwsram_cmd import lwsram_pkg::*; #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  lane_t         lane_we_n,
  input  logic          sleep,
  output logic          s1_wr,
  output logic          s1_rd,
  output logic [AW-1:0] s1_addr,
  output lane_t         s1_mask
);
  logic accept;
  assign accept = ~sleep & ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_wr   <= 1'b0;
      s1_rd   <= 1'b0;
      s1_addr <= '0;
      s1_mask <= '0;
    end else begin
      s1_wr <= accept & ~we_n;
      s1_rd <= accept & we_n;
      if (accept) begin
        s1_addr <= addr;
        s1_mask <= ~lane_we_n;
      end
    end
  end

  AST_SLEEP_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !(s1_wr || s1_rd)); // R9
endmodule

// File: rtl/lwsram_pend.sv
module lwsram_pend import lwsram_pkg::*; #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s1_wr,
  input  logic [AW-1:0] s1_addr,
  input  lane_t         s1_mask,
  input  word_t         wdata,
  input  logic          sleep,
  input  logic [AW-1:0] rd_addr,
  output logic [AW-1:0] pend_addr,
  output lane_t         pend_mask,
  output word_t         pend_data,
  output logic          commit_en,
  output logic          fwd_hit
);
  logic pend_v;

  // Retire the buffer when a newer write lands in it or sleep is requested.
  assign commit_en = pend_v & (s1_wr | sleep);
  assign fwd_hit   = pend_v & (pend_addr == rd_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_mask <= '0;
      pend_data <= '0;
    end else if (s1_wr) begin
      pend_v    <= 1'b1;
      pend_addr <= s1_addr;
      pend_mask <= s1_mask;
      pend_data <= wdata;
    end else if (sleep) begin
      pend_v    <= 1'b0;
    end
  end

  AST_LATE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    s1_wr |=> (pend_v && pend_addr == $past(s1_addr) && pend_data == $past(wdata))); // R2
  AST_SLEEP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && pend_v && !s1_wr) |=> !pend_v); // R10
endmodule

// File: rtl/lwsram_array.sv
module lwsram_array import lwsram_pkg::*; #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  lane_t         wr_mask,
  input  word_t         wr_data,
  input  logic [AW-1:0] rd_addr,
  output word_t         rd_word
);
  localparam int DEPTH = 1 << AW;

  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= merge_lanes(mem[wr_addr], wr_data, wr_mask);
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/lwsram_out.sv
module lwsram_out import lwsram_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  s1_rd,
  input  word_t arr_word,
  input  word_t pend_data,
  input  lane_t pend_mask,
  input  logic  fwd_hit,
  input  logic  oe_n,
  input  logic  sleep,
  output word_t rdata,
  output logic  rdata_en
);
  word_t rd_word;
  logic  drv_q;

  // Per-lane bypass: a lane comes from the pending buffer only on an address hit.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_word[g*LANE_W +: LANE_W] = (fwd_hit && pend_mask[g]) ?
      pend_data[g*LANE_W +: LANE_W] : arr_word[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      drv_q <= 1'b0;
    end else begin
      drv_q <= s1_rd;
      if (s1_rd) rdata <= rd_word;
    end
  end

  assign rdata_en = drv_q & ~oe_n & ~sleep;

  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_en); // R8
  AST_SLEEP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rdata_en); // R9
endmodule

// File: rtl/lwsram_front.sv
module lwsram_front import lwsram_pkg::*; #(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic [AW-1:0]     addr,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rdata_en
);
  logic          s1_wr, s1_rd, commit_en, fwd_hit;
  logic [AW-1:0] s1_addr, pend_addr;
  lane_t         s1_mask, pend_mask;
  word_t         pend_data, arr_word;

  lwsram_cmd #(.AW(AW)) cmd_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .addr(addr),
    .lane_we_n(lane_we_n), .sleep(sleep), .s1_wr(s1_wr), .s1_rd(s1_rd),
    .s1_addr(s1_addr), .s1_mask(s1_mask));

  lwsram_pend #(.AW(AW)) pend_i (
    .clk(clk), .rst_n(rst_n), .s1_wr(s1_wr), .s1_addr(s1_addr),
    .s1_mask(s1_mask), .wdata(wdata), .sleep(sleep), .rd_addr(s1_addr),
    .pend_addr(pend_addr), .pend_mask(pend_mask), .pend_data(pend_data),
    .commit_en(commit_en), .fwd_hit(fwd_hit));

  lwsram_array #(.AW(AW)) array_i (
    .clk(clk), .wr_en(commit_en), .wr_addr(pend_addr), .wr_mask(pend_mask),
    .wr_data(pend_data), .rd_addr(s1_addr), .rd_word(arr_word));

  lwsram_out out_i (
    .clk(clk), .rst_n(rst_n), .s1_rd(s1_rd), .arr_word(arr_word),
    .pend_data(pend_data), .pend_mask(pend_mask), .fwd_hit(fwd_hit),
    .oe_n(oe_n), .sleep(sleep), .rdata(rdata), .rdata_en(rdata_en));

  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ##1 !rdata_en); // R7
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n && !sleep) |=> ##1 (oe_n || sleep || rdata_en)); // R4
endmodule

// File: tb/lwsram_front_tb_top.sv
module lwsram_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NV = 18;
  localparam int NK = NV + 2;

  typedef struct packed {
    logic        cs_n;
    logic        we_n;
    logic [5:0]  addr;
    logic [3:0]  be_n;
    logic [35:0] data;
    logic        oe_n;
    logic        sleep;
    logic [3:0]  tag;
  } vec_t;

  localparam vec_t NOPV = '{1'b1, 1'b1, 6'd0, 4'hF, 36'h0, 1'b0, 1'b0, 4'd0};
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 6'd1, 4'b0000, 36'h123456789, 1'b0, 1'b0, 4'd2},
    '{1'b0, 1'b0, 6'd2, 4'b0000, 36'hABCDEF012, 1'b0, 1'b0, 4'd6},
    '{1'b0, 1'b1, 6'd1, 4'b1111, 36'h0,         1'b0, 1'b0, 4'd6},
    '{1'b0, 1'b1, 6'd2, 4'b1111, 36'h0,         1'b0, 1'b0, 4'd5},
    '{1'b0, 1'b0, 6'd1, 4'b1110, 36'hF0F0F0155, 1'b0, 1'b0, 4'd3},
    '{1'b0, 1'b1, 6'd1, 4'b1111, 36'h0,         1'b0, 1'b0, 4'd5},
    '{1'b0, 1'b0, 6'd1, 4'b1111, 36'hFFFFFFFFF, 1'b0, 1'b0, 4'd3},
    '{1'b0, 1'b1, 6'd1, 4'b1111, 36'h0,         1'b0, 1'b0, 4'd3},
    '{1'b0, 1'b0, 6'd3, 4'b0000, 36'h111111111, 1'b0, 1'b0, 4'd2},
    '{1'b0, 1'b0, 6'd3, 4'b1010, 36'h9C4E2B7A5, 1'b0, 1'b0, 4'd3},
    '{1'b0, 1'b1, 6'd3, 4'b1111, 36'h0,         1'b0, 1'b0, 4'd5},
    '{1'b1, 1'b0, 6'd3, 4'b0000, 36'h55AA55AA5, 1'b0, 1'b0, 4'd7},
    '{1'b0, 1'b1, 6'd2, 4'b1111, 36'h0,         1'b1, 1'b0, 4'd8},
    '{1'b0, 1'b1, 6'd3, 4'b1111, 36'h0,         1'b1, 1'b0, 4'd7},
    '{1'b0, 1'b0, 6'd4, 4'b0000, 36'h3C3C3C3C3, 1'b0, 1'b0, 4'd2},
    '{1'b0, 1'b1, 6'd4, 4'b1111, 36'h0,         1'b0, 1'b1, 4'd9},
    '{1'b0, 1'b1, 6'd2, 4'b1111, 36'h0,         1'b0, 1'b1, 4'd9},
    '{1'b0, 1'b1, 6'd4, 4'b1111, 36'h0,         1'b0, 1'b0, 4'd9}
  };

  logic          clk, rst_n, cs_n, we_n, oe_n, sleep, rdata_en;
  logic [AW-1:0] addr;
  logic [3:0]    lane_we_n;
  logic [35:0]   wdata, rdata;
  int checks = 0;
  int errors = 0;

  lwsram_front #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .addr(addr),
    .lane_we_n(lane_we_n), .oe_n(oe_n), .sleep(sleep), .wdata(wdata),
    .rdata(rdata), .rdata_en(rdata_en));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tag_str(int t);
    case (t)
      2: return "R2";
      3: return "R3";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      9: return "R9";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [35:0] put_lanes(logic [35:0] old, logic [35:0] nw, logic [3:0] be_n);
    logic [35:0] r;
    r = old;
    for (int i = 0; i < 4; i++) if (!be_n[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  task automatic chk(input string tag, input logic got_en, input logic exp_en,
                     input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (got_en !== exp_en || (exp_en && got !== exp)) begin
      errors++;
      $display("FAIL %s: rdata_en=%0b rdata=%h, expected rdata_en=%0b rdata=%h",
               tag, got_en, got, exp_en, exp);
    end
  endtask

  // Drive at a falling edge, pass one rising edge, return at the next falling edge.
  task automatic cyc(input logic c, input logic w, input logic [AW-1:0] a,
                     input logic [3:0] b, input logic [35:0] d);
    cs_n = c; we_n = w; addr = a; lane_we_n = b; wdata = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; sleep = 1'b0;
    addr = '0; lane_we_n = 4'hF; wdata = '0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  logic [35:0] ref_mem [64];
  logic        acc_rd [NK];
  logic        acc_wr [NK];
  logic        oe_h [NK];
  logic        sl_h [NK];
  logic [35:0] rd_exp [NK];
  logic [35:0] wd_h [NK];
  logic [5:0]  wa_h [NK];
  logic [3:0]  wb_h [NK];
  int          tag_h [NK];

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vec_t row;
    do_reset();
    chk("R11", rdata_en, 1'b0, rdata, '0);

    // Table walk with a reference memory that updates as soon as write data arrives.
    for (int k = 0; k < NK; k++) begin
      row = (k < NV) ? VEC[k] : NOPV;
      if (k >= 2)
        chk(tag_str(tag_h[k-2]), rdata_en, acc_rd[k-2] && !oe_h[k-1] && !sl_h[k-1],
            rdata, rd_exp[k-2]);
      if (k >= 1 && acc_wr[k-1])
        ref_mem[wa_h[k-1]] = put_lanes(ref_mem[wa_h[k-1]], wd_h[k-1], wb_h[k-1]);
      acc_rd[k] = !row.sleep && !row.cs_n && row.we_n;
      acc_wr[k] = !row.sleep && !row.cs_n && !row.we_n;
      rd_exp[k] = acc_rd[k] ? ref_mem[row.addr] : '0;
      oe_h[k] = row.oe_n; sl_h[k] = row.sleep; tag_h[k] = int'(row.tag);
      wa_h[k] = row.addr; wb_h[k] = row.be_n; wd_h[k] = row.data;
      oe_n = row.oe_n; sleep = row.sleep;
      cyc(row.cs_n, row.we_n, row.addr, row.be_n,
          (k >= 1 && acc_wr[k-1]) ? wd_h[k-1] : 36'h0);
    end

    // R1: a select pulse wholly between edges starts nothing.
    cs_n = 1'b0; we_n = 1'b1; addr = 6'd1;
    #(CLK_PERIOD/4);
    cs_n = 1'b1;
    @(posedge clk); @(negedge clk);
    cyc(1'b1, 1'b1, 6'd0, 4'hF, 36'h0);
    chk("R1", rdata_en, 1'b0, rdata, '0);

    // R4: not driven right after the read edge, driven one edge later.
    cyc(1'b0, 1'b1, 6'd1, 4'hF, 36'h0);
    chk("R4", rdata_en, 1'b0, rdata, '0);
    cyc(1'b1, 1'b1, 6'd0, 4'hF, 36'h0);
    chk("R4", rdata_en, 1'b1, rdata, ref_mem[1]);
    // R8 / R9: asynchronous gating inside one cycle.
    oe_n = 1'b1; #1;
    chk("R8", rdata_en, 1'b0, rdata, '0);
    oe_n = 1'b0; #1;
    chk("R8", rdata_en, 1'b1, rdata, ref_mem[1]);
    sleep = 1'b1; #1;
    chk("R9", rdata_en, 1'b0, rdata, '0);
    sleep = 1'b0; #1;
    @(negedge clk);

    // R10: pending write flushed by sleep survives a reset.
    cyc(1'b0, 1'b0, 6'd8, 4'b0000, 36'h0);
    sleep = 1'b1;
    cyc(1'b1, 1'b1, 6'd0, 4'hF, 36'h8BADF00D1);
    cyc(1'b1, 1'b1, 6'd0, 4'hF, 36'h0);
    do_reset();
    cyc(1'b0, 1'b1, 6'd8, 4'hF, 36'h0);
    cyc(1'b1, 1'b1, 6'd0, 4'hF, 36'h0);
    chk("R10", rdata_en, 1'b1, rdata, 36'h8BADF00D1);

    // R11: reset drops the pending write but keeps committed words.
    cyc(1'b0, 1'b0, 6'd9, 4'b0000, 36'h0);
    cyc(1'b0, 1'b0, 6'd10, 4'b0000, 36'h0DB0DB0DB);
    cyc(1'b0, 1'b0, 6'd9, 4'b0000, 36'h0DC0DC0DC);
    cyc(1'b1, 1'b1, 6'd0, 4'hF, 36'h0DE0DE0DE);
    do_reset();
    chk("R11", rdata_en, 1'b0, rdata, '0);
    cyc(1'b0, 1'b1, 6'd9, 4'hF, 36'h0);
    cyc(1'b1, 1'b1, 6'd0, 4'hF, 36'h0);
    chk("R11", rdata_en, 1'b1, rdata, 36'h0DB0DB0DB);
    // R6: the write to address 10 was committed by the following write.
    cyc(1'b0, 1'b1, 6'd10, 4'hF, 36'h0);
    cyc(1'b1, 1'b1, 6'd0, 4'hF, 36'h0);
    chk("R6", rdata_en, 1'b1, rdata, 36'h0DC0DC0DC);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule